// File: doc/BRIEF.md
# Strobe-Driven Ring-Pointer FIFO

This block is a small first-in first-out buffer of 16 words by 4 bits. A producer pushes words with a load strobe and a consumer pops them with an unload strobe. Both strobes are asynchronous levels, each with its own idle level. The block samples each strobe into the system clock domain through a two-flop synchronizer. It then acts on the edge that returns the strobe to idle. For the load strobe, which idles low, that is the falling edge. For the unload strobe, which idles high, that is the rising edge.

The write and read addresses are one-hot rings that rotate by one position per accepted operation. The full and empty states are set by checking whether one ring is one step behind the other. The word at the read position is shown at the data outputs as soon as it is stored, so the head word falls through. An input-ready flag and an output-ready flag tell the two sides when they may act. Each flag is raised only while its own strobe rests at its idle level. An output enable gates only the data outputs.

Top module: `strobe_ring_fifo`

## Requirements
- R1: Words leave in the same order they were stored. While the buffer is not empty and `out_en` is high, `dout` shows the oldest stored word.
- R2: A high-to-low transition of `load_stb` stores `din`. It takes effect on the third rising clock edge after the input changes. `out_rdy` is still low two edges after a load into an empty buffer and high after the third edge.
- R3: A low-to-high transition of `unload_stb` removes the oldest word. It takes effect on the third rising clock edge after the input changes.
- R4: The buffer is full when it holds 16 words. A load transition while full leaves the contents and the word order unchanged.
- R5: An unload transition while the buffer is empty has no effect. `out_rdy` stays low and a later load is the next word read.
- R6: `in_rdy` is high exactly when the buffer is not full and the synchronized `load_stb` is low.
- R7: `out_rdy` is high exactly when the buffer is not empty and the synchronized `unload_stb` is high.
- R8: A low `clr_n`, sampled on a clock edge, empties the buffer and returns both pointers to their start. `out_rdy` goes low and `in_rdy` goes high while `load_stb` is idle.
- R9: With `out_en` low, `dout` reads 0 and `dout_drive` is low. `in_rdy` and `out_rdy` are unaffected.
- R10: If a load edge and an unload edge are seen in the same clock cycle, both act. Full and empty are judged as they stood before that cycle: a full buffer only reads and an empty buffer only writes.
- R11: A high `rst`, sampled on a clock edge, empties the buffer and sets both synchronizers to their idle levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low buffer clear |
| load_stb | input | 1 | Load strobe, idle low, writes on falling edge |
| unload_stb | input | 1 | Unload strobe, idle high, reads on rising edge |
| out_en | input | 1 | Enables the data outputs |
| din | input | 4 | Word to store |
| dout | output | 4 | Oldest stored word, 0 when disabled |
| dout_drive | output | 1 | High when `dout` should drive the bus |
| in_rdy | output | 1 | Not full and load strobe idle |
| out_rdy | output | 1 | Not empty and unload strobe idle |

## Verification
The assertions assume that each strobe level is held for at least two clock cycles. This lets the synchronizer see every transition as one clean edge. They also assume that `din` is stable from the load strobe's fall until the write lands three edges later. The stimulus drives every input on the falling clock edge and holds each strobe level for four cycles. It keeps `din` fixed until after the write. Simultaneous operations are produced by changing both strobes on the same falling edge.

// File: rtl/strobe_ring_fifo_pkg.sv
`timescale 1ns/1ps
package strobe_ring_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_WIDTH = 4;

  // operations accepted in one cycle after full/empty gating
  typedef struct packed {
    logic wr;
    logic rd;
  } fifo_ops_t;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter logic IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic lvl,
  output logic evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= strobe;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl = s2;
  // act when the strobe returns to its resting level
  assign evt = (s2 == IDLE) && (s3 != IDLE);

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R2
endmodule

// File: rtl/ring_ptr.sv
`timescale 1ns/1ps
module ring_ptr #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [DEPTH-1:0] ptr,
  output logic [DEPTH-1:0] nxt
);
  localparam logic [DEPTH-1:0] START = DEPTH'(1);

  assign nxt = {ptr[DEPTH-2:0], ptr[DEPTH-1]};

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= START;
    else if (adv)   ptr <= nxt;
  end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(ptr) == 1); // R1
endmodule

// File: rtl/ptr_compare.sv
`timescale 1ns/1ps
module ptr_compare #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             we,
  input  logic             re,
  input  logic [DEPTH-1:0] wr_ptr,
  input  logic [DEPTH-1:0] wr_nxt,
  input  logic [DEPTH-1:0] rd_ptr,
  input  logic [DEPTH-1:0] rd_nxt,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end else if (we && !re) begin
      empty <= 1'b0;
      full  <= (wr_nxt == rd_ptr);
    end else if (re && !we) begin
      full  <= 1'b0;
      empty <= (rd_nxt == wr_ptr);
    end
  end

  AST_EQ_PTRS: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr == rd_ptr) == (full || empty)); // R4
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R4
endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/1ps
module fifo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [DEPTH-1:0] wsel,
  input  logic [DEPTH-1:0] rsel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && wsel[i]) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      rdata = rdata | (mem[i] & {WIDTH{rsel[i]}});
    end
  end
endmodule

// File: rtl/strobe_ring_fifo.sv
`timescale 1ns/1ps
module strobe_ring_fifo
  import strobe_ring_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = DEF_DEPTH,
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             load_stb,
  input  logic             unload_stb,
  input  logic             out_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_drive,
  output logic             in_rdy,
  output logic             out_rdy
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             ld_lvl, ld_evt, ul_lvl, ul_evt;
  logic             clr, full, empty;
  fifo_ops_t        ops;
  logic [DEPTH-1:0] wr_ptr, wr_nxt, rd_ptr, rd_nxt;
  logic [WIDTH-1:0] head;
  logic [CNT_W-1:0] occ;

  assign clr = !clr_n;

  strobe_sync #(.IDLE(1'b0)) u_ld_sync (
    .clk(clk), .rst(rst), .strobe(load_stb), .lvl(ld_lvl), .evt(ld_evt));
  strobe_sync #(.IDLE(1'b1)) u_ul_sync (
    .clk(clk), .rst(rst), .strobe(unload_stb), .lvl(ul_lvl), .evt(ul_evt));

  assign ops.wr = ld_evt && !full  && !clr;
  assign ops.rd = ul_evt && !empty && !clr;

  ring_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk(clk), .rst(rst), .clr(clr), .adv(ops.wr), .ptr(wr_ptr), .nxt(wr_nxt));
  ring_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk(clk), .rst(rst), .clr(clr), .adv(ops.rd), .ptr(rd_ptr), .nxt(rd_nxt));

  ptr_compare #(.DEPTH(DEPTH)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .we(ops.wr), .re(ops.rd),
    .wr_ptr(wr_ptr), .wr_nxt(wr_nxt), .rd_ptr(rd_ptr), .rd_nxt(rd_nxt),
    .full(full), .empty(empty));

  fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(ops.wr), .wsel(wr_ptr), .rsel(rd_ptr),
    .wdata(din), .rdata(head));

  assign in_rdy     = !full && !ld_lvl;
  assign out_rdy    = !empty && ul_lvl;
  assign dout_drive = out_en;
  assign dout       = out_en ? head : '0;

  // occupancy shadow, used only as a cross-check of the pointer flags
  always_ff @(posedge clk) begin
    if (rst || clr) occ <= '0;
    else            occ <= occ + CNT_W'(ops.wr) - CNT_W'(ops.rd);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (occ <= CNT_W'(DEPTH)) && (full == (occ == CNT_W'(DEPTH)))); // R4
  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    empty == (occ == '0)); // R5
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (full && ld_evt && !ul_evt && clr_n) |=> $stable(wr_ptr)); // R4
  AST_EMPTY_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (empty && ul_evt && !ld_evt && clr_n) |=> $stable(rd_ptr)); // R5
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (!out_rdy && wr_ptr == rd_ptr)); // R8
  AST_BOTH_OPS: assert property (@(posedge clk) disable iff (rst)
    (ld_evt && ul_evt && !full && !empty && clr_n) |=> $stable(occ)); // R10
endmodule

// File: tb/strobe_ring_fifo_tb.sv
`timescale 1ns/1ps
module strobe_ring_fifo_tb;
  logic       clk = 1'b0;
  logic       rst, clr_n, load_stb, unload_stb, out_en;
  logic [3:0] din, dout;
  logic       dout_drive, in_rdy, out_rdy;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  strobe_ring_fifo u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_stb(load_stb),
    .unload_stb(unload_stb), .out_en(out_en), .din(din), .dout(dout),
    .dout_drive(dout_drive), .in_rdy(in_rdy), .out_rdy(out_rdy));

  // {op[13:12] 0=load 1=unload, din[11:8], chk[7], dout[6:3], pad[2], ir[1], or[0]}
  localparam logic [13:0] VEC [9] = '{
    {2'd0, 4'h5, 1'b1, 4'h5, 1'b0, 1'b1, 1'b1},
    {2'd0, 4'hA, 1'b1, 4'h5, 1'b0, 1'b1, 1'b1},
    {2'd0, 4'h3, 1'b1, 4'h5, 1'b0, 1'b1, 1'b1},
    {2'd1, 4'h0, 1'b1, 4'hA, 1'b0, 1'b1, 1'b1},
    {2'd1, 4'h0, 1'b1, 4'h3, 1'b0, 1'b1, 1'b1},
    {2'd1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
    {2'd1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
    {2'd0, 4'hC, 1'b1, 4'hC, 1'b0, 1'b1, 1'b1},
    {2'd1, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R2: falling load edge stores din
  task automatic do_load(input logic [3:0] d);
    din = d; load_stb = 1'b1; step(4);
    load_stb = 1'b0; step(4);
  endtask

  // R3: rising unload edge removes the head
  task automatic do_unload();
    unload_stb = 1'b0; step(4);
    unload_stb = 1'b1; step(4);
  endtask

  // R10: both edges in the same cycle
  task automatic do_both(input logic [3:0] d);
    din = d; load_stb = 1'b1; unload_stb = 1'b0; step(4);
    load_stb = 1'b0; unload_stb = 1'b1; step(4);
  endtask

  task automatic apply_clear();
    clr_n = 1'b0; step(1); clr_n = 1'b1; step(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst = 1'b1; clr_n = 1'b1; load_stb = 1'b0; unload_stb = 1'b1;
    out_en = 1'b1; din = 4'h0;
    step(3); rst = 1'b0; step(1);

    // R11 reset state
    chk("R11", "in_rdy after reset", {3'b0, in_rdy}, 4'h1);
    chk("R11", "out_rdy after reset", {3'b0, out_rdy}, 4'h0);
    chk("R9", "dout_drive enabled", {3'b0, dout_drive}, 4'h1);

    // table walk: R1 ordering, R6/R7 flags, R5 unload on empty
    for (int i = 0; i < 9; i++) begin
      if (VEC[i][13:12] == 2'd0) do_load(VEC[i][11:8]);
      else                       do_unload();
      if (VEC[i][7]) chk("R1", "dout order", dout, VEC[i][6:3]);
      chk("R6", "in_rdy", {3'b0, in_rdy}, {3'b0, VEC[i][1]});
      chk("R7", "out_rdy", {3'b0, out_rdy}, {3'b0, VEC[i][0]});
    end

    // R5: after unloads on empty, next load is the head
    do_unload();
    chk("R5", "out_rdy stays low", {3'b0, out_rdy}, 4'h0);
    do_load(4'h6);
    chk("R5", "next load is head", dout, 4'h6);
    do_unload();

    // R2 timing: store lands on third edge
    din = 4'h9; load_stb = 1'b1; step(4);
    chk("R6", "in_rdy low while load high", {3'b0, in_rdy}, 4'h0);
    load_stb = 1'b0; step(2);
    chk("R2", "out_rdy after two edges", {3'b0, out_rdy}, 4'h0);
    step(1);
    chk("R2", "out_rdy after three edges", {3'b0, out_rdy}, 4'h1);
    step(2);
    // R3 timing and R7 qualification
    unload_stb = 1'b0; step(4);
    chk("R7", "out_rdy low while unload low", {3'b0, out_rdy}, 4'h0);
    unload_stb = 1'b1; step(2);
    chk("R3", "word still held after two edges", dout, 4'h9);
    step(1);
    chk("R3", "out_rdy low after third edge", {3'b0, out_rdy}, 4'h0);
    step(2);

    // R4: fill across the ring wrap, overflow load ignored
    for (int i = 0; i < 16; i++) do_load(4'(i));
    chk("R4", "in_rdy when full", {3'b0, in_rdy}, 4'h0);
    chk("R4", "out_rdy when full", {3'b0, out_rdy}, 4'h1);
    do_load(4'hF);
    chk("R4", "head unchanged after overflow load", dout, 4'h0);
    for (int i = 0; i < 16; i++) begin
      chk("R4", "drain order", dout, 4'(i));
      do_unload();
    end
    chk("R4", "empty after drain", {3'b0, out_rdy}, 4'h0);

    // R10: simultaneous on empty writes only
    do_both(4'h7);
    chk("R10", "empty: write only", {3'b0, out_rdy}, 4'h1);
    chk("R10", "empty: head", dout, 4'h7);
    do_both(4'h8);
    chk("R10", "one word: both act", dout, 4'h8);
    do_unload();
    chk("R10", "one word: count kept", {3'b0, out_rdy}, 4'h0);

    // R10: simultaneous on full reads only
    for (int i = 0; i < 16; i++) do_load(4'(i));
    do_both(4'hE);
    chk("R10", "full: read only, in_rdy", {3'b0, in_rdy}, 4'h1);
    chk("R10", "full: head advanced", dout, 4'h1);
    for (int i = 1; i < 16; i++) begin
      chk("R10", "full: remaining order", dout, 4'(i));
      do_unload();
    end
    chk("R10", "full: write was dropped", {3'b0, out_rdy}, 4'h0);

    // R8 clear
    do_load(4'h2); do_load(4'h4);
    apply_clear();
    chk("R8", "out_rdy after clear", {3'b0, out_rdy}, 4'h0);
    chk("R8", "in_rdy after clear", {3'b0, in_rdy}, 4'h1);
    do_load(4'hB);
    chk("R8", "fresh head after clear", dout, 4'hB);

    // R9 output enable
    out_en = 1'b0; step(1);
    chk("R9", "dout disabled", dout, 4'h0);
    chk("R9", "dout_drive disabled", {3'b0, dout_drive}, 4'h0);
    chk("R9", "out_rdy unaffected", {3'b0, out_rdy}, 4'h1);
    chk("R9", "in_rdy unaffected", {3'b0, in_rdy}, 4'h1);
    out_en = 1'b1; step(1);
    chk("R9", "dout restored", dout, 4'hB);

    // R11 reset mid-run
    rst = 1'b1; step(2); rst = 1'b0; step(1);
    chk("R11", "out_rdy after mid reset", {3'b0, out_rdy}, 4'h0);
    chk("R11", "in_rdy after mid reset", {3'b0, in_rdy}, 4'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule